// File: doc/BRIEF.md
# Dual-Time Input Debounce Filter

This block cleans up a word of slowly sampled digital inputs, such as switches or relay contacts that are read one scan at a time through an external expander. Every bit of the raw input word has its own debounce state. A change on a raw bit reaches the filtered word only after the raw bit has held its new value for a set number of consecutive scans. The scan rate comes from a one-cycle strobe supplied by the scanning logic.

Two debounce periods are shared by all bits: a short one held in a 6-bit field and a long one held in a 10-bit field. Both are counted in scans. A per-bit select word picks which of the two periods applies to each input, so fast sensors and noisy mechanical contacts can sit in the same word. The filtered word is a plain register output, ready to be placed on the register bus by the surrounding logic.

Top module: `dual_time_debounce`

## Requirements
- R1: While rst_n is low at a clock edge, the filtered word becomes all zeros and every bit's scan count becomes zero.
- R2: With a selected period of T scans, a filtered bit takes the raw bit's value at the (T+1)-th consecutive scan strobe at which the raw bit differs from the filtered bit, and not earlier.
- R3: Bit n of long_sel chooses the period: 1 selects long_time and 0 selects short_time for input n.
- R4: A selected period of 0 passes a raw change to the filtered bit at the first scan strobe after the change.
- R5: In any clock cycle where a raw bit equals its filtered bit, that bit's scan count returns to zero, so a bounce that returns to the old value restarts the full period.
- R6: In a cycle without a scan strobe, no filtered bit changes and no scan count advances.
- R7: A change of long_sel, short_time or long_time does not clear a count already running; the next strobe compares the running count with the newly selected period and, if the count already meets or exceeds it, the filtered bit takes the raw value at that strobe.
- R8: The full long range is honoured: with long_time at 1023, a bit needs 1024 consecutive differing strobes before it changes.
- R9: Each bit is filtered independently; the count and the period of one bit have no effect on any other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_word | input | WIDTH | Raw demultiplexed inputs, one bit per input |
| scan_tick | input | 1 | One-cycle strobe marking the end of a scan |
| short_time | input | SHORT_W | Short debounce period in scans |
| long_time | input | LONG_W | Long debounce period in scans |
| long_sel | input | WIDTH | Per-bit period select, 1 = long, 0 = short |
| filt_word | output | WIDTH | Debounced inputs |

## Verification
The assertions assume scan_tick is a strobe sampled on the same clock as the raw word and that the raw word is already synchronous to that clock; the bench drives every input on the falling edge so each rising edge sees stable values. They also assume the period fields and the select word may change on any cycle, which the bench exploits when it shortens a period or flips a select in the middle of a running count. Raw words are held across several strobes and only changed between strobes, so every counted scan sees one defined raw value.

// File: rtl/debounce_pkg.sv
// Package: shared widths and helpers for the dual-time debounce filter.
// Assumes nothing beyond the defaults below being the field sizes of
// the control word that feeds the filter.
package debounce_pkg;

    // Default width of the short period field (scans).
    localparam int SHORT_W_DEF = 6;
    // Default width of the long period field (scans).
    localparam int LONG_W_DEF  = 10;
    // Default number of inputs per scanned word.
    localparam int WIDTH_DEF   = 32;

    // Larger of two widths, used to size the per-bit scan counter.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/debounce_period_sel.sv
// Module: debounce_period_sel
// Expands the two shared periods into one period per input bit, as the
// per-bit select word chooses. Purely combinational; assumes both period
// fields fit in CNT_W bits.
module debounce_period_sel #(
    parameter int WIDTH   = debounce_pkg::WIDTH_DEF,
    parameter int SHORT_W = debounce_pkg::SHORT_W_DEF,
    parameter int LONG_W  = debounce_pkg::LONG_W_DEF,
    parameter int CNT_W   = debounce_pkg::max_w(SHORT_W, LONG_W)
) (
    input  logic [SHORT_W-1:0]          short_time,
    input  logic [LONG_W-1:0]           long_time,
    input  logic [WIDTH-1:0]            long_sel,
    output logic [WIDTH-1:0][CNT_W-1:0] bit_period
);

    logic [CNT_W-1:0] short_ext;
    logic [CNT_W-1:0] long_ext;

    // Widen both periods to the counter width.
    always_comb begin
        short_ext = CNT_W'(short_time);
        long_ext  = CNT_W'(long_time);
    end

    for (genvar n = 0; n < WIDTH; n++) begin : g_sel
        // Pick the period for input n.
        always_comb begin
            bit_period[n] = long_sel[n] ? long_ext : short_ext;
        end
    end

endmodule

// File: rtl/debounce_cell.sv
// Module: debounce_cell
// Debounce state for one input bit: a scan counter and the filtered bit.
// The counter runs only on scan strobes while raw and filtered disagree,
// and is cleared in any cycle they agree. The filtered bit follows raw
// at the strobe where the count already meets the period. Assumes the
// raw bit is synchronous to clk.
module debounce_cell #(
    parameter int CNT_W = debounce_pkg::max_w(debounce_pkg::SHORT_W_DEF,
                                              debounce_pkg::LONG_W_DEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             raw_bit,
    input  logic [CNT_W-1:0] period,
    output logic             filt_bit
);

    logic [CNT_W-1:0] scan_cnt;
    logic             differs;
    logic             expire;

    // Detect disagreement and expiry of the selected period.
    always_comb begin
        differs = (raw_bit != filt_bit);
        expire  = differs && scan_tick && (scan_cnt >= period);
    end

    // Advance, clear or settle the scan counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_cnt <= '0;
        end else if (!differs || expire) begin
            scan_cnt <= '0;
        end else if (scan_tick) begin
            scan_cnt <= scan_cnt + CNT_W'(1);
        end
    end

    // Take over the raw value once the period has run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_bit <= 1'b0;
        end else if (expire) begin
            filt_bit <= raw_bit;
        end
    end

    // R1: reset leaves a cleared cell.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (filt_bit == 1'b0) && (scan_cnt == '0));

    // R6: no strobe, no change of the filtered bit.
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(filt_bit));

    // R6: no strobe, the count does not climb.
    assert_cnt_no_climb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && rst_n) |=> (scan_cnt == '0) || $stable(scan_cnt));

    // R5: agreement empties the count.
    assert_agree_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_bit == filt_bit) |=> (scan_cnt == '0));

    // R2: the filtered bit only ever moves to the raw value it saw.
    assert_moves_to_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_bit != $past(filt_bit)) |-> (filt_bit == $past(raw_bit)));

    // R7: a strobe with a met period settles the bit, even after a period change.
    assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && (raw_bit != filt_bit) && (scan_cnt >= period)) |=>
        (filt_bit == $past(raw_bit)));

endmodule

// File: rtl/dual_time_debounce.sv
// Module: dual_time_debounce (top)
// Debounces every bit of a scanned input word with one of two shared
// periods, counted in scan strobes. Assumes scan_tick is a one-cycle
// strobe and that all inputs are synchronous to clk.
module dual_time_debounce #(
    parameter int WIDTH   = debounce_pkg::WIDTH_DEF,
    parameter int SHORT_W = debounce_pkg::SHORT_W_DEF,
    parameter int LONG_W  = debounce_pkg::LONG_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   raw_word,
    input  logic               scan_tick,
    input  logic [SHORT_W-1:0] short_time,
    input  logic [LONG_W-1:0]  long_time,
    input  logic [WIDTH-1:0]   long_sel,
    output logic [WIDTH-1:0]   filt_word
);

    localparam int CNT_W = debounce_pkg::max_w(SHORT_W, LONG_W);

    logic [WIDTH-1:0][CNT_W-1:0] bit_period;

    debounce_period_sel #(
        .WIDTH   (WIDTH),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W),
        .CNT_W   (CNT_W)
    ) u_sel (
        .short_time (short_time),
        .long_time  (long_time),
        .long_sel   (long_sel),
        .bit_period (bit_period)
    );

    for (genvar n = 0; n < WIDTH; n++) begin : g_cell
        debounce_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .scan_tick (scan_tick),
            .raw_bit   (raw_word[n]),
            .period    (bit_period[n]),
            .filt_bit  (filt_word[n])
        );
    end

    // R9: bits that already agree with raw stay put at any edge.
    assert_agree_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(raw_word) ~^ $past(filt_word)) & (filt_word ^ $past(filt_word))) == '0));

endmodule

// File: tb/sim_dual_time_debounce.sv
module sim_dual_time_debounce;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] raw_word = '0;
    logic         scan_tick = 1'b0;
    logic [5:0]   short_time = 6'd2;
    logic [9:0]   long_time = 10'd5;
    logic [W-1:0] long_sel = '0;
    logic [W-1:0] filt_word;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_time_debounce #(.WIDTH(W), .SHORT_W(6), .LONG_W(10)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .scan_tick(scan_tick),
        .short_time(short_time), .long_time(long_time), .long_sel(long_sel),
        .filt_word(filt_word)
    );

    // raw, select, short, long, strobes, expected filtered word
    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] sel;
        logic [5:0]   sh;
        logic [9:0]   lg;
        logic [11:0]  n;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'hFF, 8'h00, 6'd2, 10'd5, 12'd2, 8'h00},  // R2 not yet
        '{8'hFF, 8'h00, 6'd2, 10'd5, 12'd1, 8'hFF},  // R2 third strobe
        '{8'h00, 8'hF0, 6'd2, 10'd5, 12'd3, 8'hF0},  // R3 short half moves
        '{8'h00, 8'hF0, 6'd2, 10'd5, 12'd2, 8'hF0},  // R3 long half waits
        '{8'h00, 8'hF0, 6'd2, 10'd5, 12'd1, 8'h00},  // R3 long half sixth strobe
        '{8'h0F, 8'h00, 6'd0, 10'd5, 12'd1, 8'h0F},  // R4 zero period
        '{8'hF0, 8'h00, 6'd2, 10'd5, 12'd2, 8'h0F},  // R5 counting
        '{8'h0F, 8'h00, 6'd2, 10'd5, 12'd0, 8'h0F},  // R5 bounce back
        '{8'hF0, 8'h00, 6'd2, 10'd5, 12'd2, 8'h0F},  // R5 restarted
        '{8'hF0, 8'h00, 6'd2, 10'd5, 12'd1, 8'hF0}   // R5 full period
    };

    task automatic check(input logic [W-1:0] exp, input string req);
        tests++;
        if (filt_word !== exp) begin
            fails++;
            $display("FAIL %s: filt_word=%h expected=%h", req, filt_word, exp);
        end
    endtask

    // Strobes with an idle cycle between; ends on a falling edge.
    task automatic strobes(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            scan_tick = 1'b1;
            @(negedge clk);
            scan_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check('0, "R1 reset");
        rst_n = 1'b1;

        for (int v = 0; v < 10; v++) begin
            raw_word = VECS[v].raw;
            long_sel = VECS[v].sel;
            short_time = VECS[v].sh;
            long_time = VECS[v].lg;
            strobes(int'(VECS[v].n));
            check(VECS[v].exp, $sformatf("R2/R3/R4/R5/R9 vector %0d", v));
        end

        // R6: raw differs for many cycles without strobes.
        raw_word = 8'h0F; short_time = 6'd0;
        repeat (20) @(negedge clk);
        check(8'hF0, "R6 no strobe");

        // R7: select change keeps running count (F0 -> 00, upper long).
        short_time = 6'd2; long_time = 10'd5;
        raw_word = 8'h00; long_sel = 8'hF0;
        strobes(2);
        check(8'hF0, "R7 before select change");
        long_sel = 8'h00;
        strobes(1);
        check(8'h00, "R7 after select change");

        // R7: long period shrinks below running count.
        raw_word = 8'hFF; long_sel = 8'hFF; long_time = 10'd5;
        strobes(4);
        check(8'h00, "R7 before period change");
        long_time = 10'd1;
        strobes(1);
        check(8'hFF, "R7 after period change");

        // R8: long period at its maximum on bit 0 only.
        raw_word = 8'h00; long_sel = 8'h01; long_time = 10'd1023; short_time = 6'd2;
        strobes(1023);
        check(8'h01, "R8 1023 strobes");
        strobes(1);
        check(8'h00, "R8 1024th strobe");

        // R1: reset in the middle of a count.
        raw_word = 8'hFF; long_sel = 8'h00; short_time = 6'd3;
        strobes(2);
        rst_n = 1'b0;
        @(negedge clk);
        check(8'h00, "R1 mid-count reset");
        rst_n = 1'b1;
        strobes(3);
        check(8'h00, "R1 count cleared by reset");
        strobes(1);
        check(8'hFF, "R1 full period after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule